// File: doc/BRIEF.md
# Nibble-Addressed Program Flow Unit

This unit owns the 20-bit program counter of a processor whose memory is addressed in 4-bit nibbles, together with a small hardware return stack. Every cycle in which the decoder presents an instruction, the unit receives four things: the kind of control transfer, the instruction length, and where the offset field sits inside the instruction, plus the immediate nibbles. It also receives a one-bit condition result from the test logic. On the next clock edge it moves the PC to the following instruction, to a relative or absolute target, to a register value, or to an address popped from the return stack.

Calls push the address of the instruction after the call. Returns pop it and can raise one side-effect pulse: set carry, clear carry, set the extended-mode flag, or re-enable interrupts. A conditional branch whose 8-bit offset is zero becomes a conditional return. The unit also exchanges the PC with a register, writes the next-instruction address into a register, jumps through a value fetched from memory, and moves a register to or from the stack. Opcode decoding, condition evaluation and the memory read for indirect jumps are done outside the unit.

The immediate arrives as a 20-bit word holding up to five nibbles in stream order. Stream nibble k occupies bits [4k+3:4k], so the least significant nibble is the first one fetched.

Top module: `nib_flow_unit`

## Requirements
- R1: While rst is high, and on the first edge after it, pc is 0, the return stack is empty, reg_we is 0 and all four return pulses are 0.
- R2: With step_op 0 (sequential) or any code from 13 to 15, pc becomes pc+step_len one cycle after a valid step.
- R3: With step_op 1 (branch) and a nonzero offset in imm[7:0], cond=1 moves pc to pc+step_pos+sign_extend(imm[7:0]). cond=0 moves pc to pc+step_len.
- R4: With step_op 1, imm[7:0]=0 and cond=1, pc is loaded from the top of the return stack and that entry is removed. With cond=0, pc becomes pc+step_len and the stack is unchanged.
- R5: With step_op 2 (relative jump), pc becomes pc+step_pos+sign_extend of the low step_nibs nibbles of imm. Widths 2, 3 and 4 are sign-extended; any other width uses all 20 bits.
- R6: With step_op 3 (relative call), pc+step_len is pushed, and pc becomes pc+step_len+sign_extend of the low step_nibs nibbles of imm.
- R7: With step_op 4 (absolute jump), pc becomes imm. With step_op 5 (absolute call), pc+step_len is pushed and pc becomes imm.
- R8: With step_op 6 (return), pc is loaded from the popped entry. One cycle later a single pulse follows step_ret: 1 raises set_carry, 2 raises clr_carry, 3 raises set_xm, 4 raises int_on, and 0 raises none. No other operation raises any of these pulses.
- R9: With step_op 7, pc becomes reg_val. With step_op 8, reg_wdata is pc+step_len with reg_we pulsed, and pc advances by step_len. With step_op 9, both happen: pc takes reg_val and the register receives pc+step_len.
- R10: With step_op 10 (indirect jump), pc becomes mem_val.
- R11: With step_op 11, reg_val is pushed and pc advances. With step_op 12, the top entry is popped into reg_wdata with reg_we pulsed, and pc advances.
- R12: The return stack holds 8 entries. A push onto a full stack discards the oldest entry, and a pop from an empty stack yields 0.
- R13: All PC arithmetic wraps modulo 2^20.
- R14: In a cycle with step_valid low, pc and the stack keep their values and reg_we and the pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | A decoded instruction is presented this cycle |
| step_op | input | 4 | Control-transfer kind (codes in R2 to R11) |
| step_len | input | 5 | Instruction length in nibbles |
| step_pos | input | 3 | Nibble position of the offset field inside the instruction |
| step_nibs | input | 3 | Width of a jump or call offset in nibbles |
| imm | input | 20 | Immediate nibbles, stream nibble k at bits [4k+3:4k] |
| cond | input | 1 | Condition result for branches |
| step_ret | input | 3 | Return side effect selector |
| reg_val | input | 20 | 20-bit field of the source register |
| mem_val | input | 20 | 20-bit value read at the address held in the register |
| pc | output | 20 | Program counter |
| reg_we | output | 1 | Register write pulse |
| reg_wdata | output | 20 | Value to write into the register |
| set_carry | output | 1 | Return pulse: set carry |
| clr_carry | output | 1 | Return pulse: clear carry |
| set_xm | output | 1 | Return pulse: set extended-mode flag |
| int_on | output | 1 | Return pulse: re-enable interrupts |

## Verification
Two things coincide in one cycle when a call lands on a full return stack: the push of the new return address and the silent loss of the oldest entry. The bench provokes this with nine absolute calls in a row. It then issues nine returns and expects the first eight to come back in reverse order, with the ninth yielding zero because the stack is empty. The zero-offset branch is judged the same way: a taken one must consume exactly one stack entry, and a not-taken one must leave the stack untouched, which a later pop reveals.

// File: rtl/nfu_pkg.sv
package nfu_pkg;
    localparam int PC_W  = 20;
    localparam int LEN_W = 5;
    localparam int POS_W = 3;

    typedef logic [PC_W-1:0] addr_t;

    typedef enum logic [3:0] {
        OP_SEQ    = 4'd0,
        OP_BRANCH = 4'd1,
        OP_JREL   = 4'd2,
        OP_CREL   = 4'd3,
        OP_JABS   = 4'd4,
        OP_CABS   = 4'd5,
        OP_RET    = 4'd6,
        OP_REG2PC = 4'd7,
        OP_PC2REG = 4'd8,
        OP_SWAPPC = 4'd9,
        OP_JIND   = 4'd10,
        OP_PUSH   = 4'd11,
        OP_POP    = 4'd12
    } flow_op_e;

    typedef enum logic [2:0] {
        RK_PLAIN = 3'd0,
        RK_SETC  = 3'd1,
        RK_CLRC  = 3'd2,
        RK_SETXM = 3'd3,
        RK_INTON = 3'd4
    } ret_kind_e;

    typedef struct packed {
        logic set_c;
        logic clr_c;
        logic set_xm;
        logic int_on;
    } ret_fx_t;

    typedef struct packed {
        addr_t   pc;
        logic    push;
        logic    pop;
        addr_t   push_val;
        logic    reg_we;
        addr_t   wr_val;
        ret_fx_t fx;
    } flow_dec_t;

    // Sign-extend the low n nibbles of v to a full address.
    function automatic addr_t sext_nibs(addr_t v, logic [2:0] n);
        case (n)
            3'd2:    return {{(PC_W-8){v[7]}},   v[7:0]};
            3'd3:    return {{(PC_W-12){v[11]}}, v[11:0]};
            3'd4:    return {{(PC_W-16){v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic ret_fx_t fx_of(ret_kind_e k);
        ret_fx_t f;
        f = '0;
        case (k)
            RK_SETC:  f.set_c  = 1'b1;
            RK_CLRC:  f.clr_c  = 1'b1;
            RK_SETXM: f.set_xm = 1'b1;
            RK_INTON: f.int_on = 1'b1;
            default:  f = '0;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/nfu_rstack.sv
module nfu_rstack
    import nfu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  logic  pop,
    input  addr_t din,
    output addr_t top
);
    addr_t ent     [DEPTH];
    addr_t from_up [DEPTH];
    addr_t from_dn [DEPTH];

    // Entry 0 is the top; a push shifts toward the bottom and drops
    // the oldest entry, a pop shifts up and fills the bottom with zero.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_first
            assign from_up[i] = din;
        end else begin : g_rest_up
            assign from_up[i] = ent[i-1];
        end
        if (i == DEPTH-1) begin : g_last
            assign from_dn[i] = '0;
        end else begin : g_rest_dn
            assign from_dn[i] = ent[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst)       ent[i] <= '0;
            else if (push) ent[i] <= from_up[i];
            else if (pop)  ent[i] <= from_dn[i];
        end
    end

    assign top = ent[0];
endmodule

// File: rtl/nfu_target.sv
module nfu_target
    import nfu_pkg::*;
(
    input  flow_op_e          op,
    input  addr_t             pc,
    input  logic [LEN_W-1:0]  len,
    input  logic [POS_W-1:0]  pos,
    input  logic [2:0]        nibs,
    input  addr_t             imm,
    input  logic              cond,
    input  ret_kind_e         rkind,
    input  addr_t             reg_val,
    input  addr_t             mem_val,
    input  addr_t             stack_top,
    output flow_dec_t         dec
);
    addr_t nxt;
    addr_t rel_base;

    assign nxt      = pc + addr_t'(len);
    assign rel_base = pc + addr_t'(pos);

    always_comb begin
        dec    = '0;
        dec.pc = nxt;
        case (op)
            OP_BRANCH: begin
                if (cond) begin
                    if (imm[7:0] == 8'h00) begin
                        dec.pc  = stack_top;
                        dec.pop = 1'b1;
                    end else begin
                        dec.pc = rel_base + sext_nibs(imm, 3'd2);
                    end
                end
            end
            OP_JREL: dec.pc = rel_base + sext_nibs(imm, nibs);
            OP_CREL: begin
                dec.pc       = nxt + sext_nibs(imm, nibs);
                dec.push     = 1'b1;
                dec.push_val = nxt;
            end
            OP_JABS: dec.pc = imm;
            OP_CABS: begin
                dec.pc       = imm;
                dec.push     = 1'b1;
                dec.push_val = nxt;
            end
            OP_RET: begin
                dec.pc  = stack_top;
                dec.pop = 1'b1;
                dec.fx  = fx_of(rkind);
            end
            OP_REG2PC: dec.pc = reg_val;
            OP_PC2REG: begin
                dec.reg_we = 1'b1;
                dec.wr_val = nxt;
            end
            OP_SWAPPC: begin
                dec.pc     = reg_val;
                dec.reg_we = 1'b1;
                dec.wr_val = nxt;
            end
            OP_JIND: dec.pc = mem_val;
            OP_PUSH: begin
                dec.push     = 1'b1;
                dec.push_val = reg_val;
            end
            OP_POP: begin
                dec.pop    = 1'b1;
                dec.reg_we = 1'b1;
                dec.wr_val = stack_top;
            end
            default: dec.pc = nxt;
        endcase
    end
endmodule

// File: rtl/nib_flow_unit.sv
module nib_flow_unit
    import nfu_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_valid,
    input  logic [3:0]       step_op,
    input  logic [LEN_W-1:0] step_len,
    input  logic [POS_W-1:0] step_pos,
    input  logic [2:0]       step_nibs,
    input  logic [PC_W-1:0]  imm,
    input  logic             cond,
    input  logic [2:0]       step_ret,
    input  logic [PC_W-1:0]  reg_val,
    input  logic [PC_W-1:0]  mem_val,
    output logic [PC_W-1:0]  pc,
    output logic             reg_we,
    output logic [PC_W-1:0]  reg_wdata,
    output logic             set_carry,
    output logic             clr_carry,
    output logic             set_xm,
    output logic             int_on
);
    addr_t     pc_q;
    addr_t     wdata_q;
    logic      we_q;
    ret_fx_t   fx_q;
    addr_t     stack_top;
    flow_dec_t dec;

    nfu_target u_target (
        .op        (flow_op_e'(step_op)),
        .pc        (pc_q),
        .len       (step_len),
        .pos       (step_pos),
        .nibs      (step_nibs),
        .imm       (imm),
        .cond      (cond),
        .rkind     (ret_kind_e'(step_ret)),
        .reg_val   (reg_val),
        .mem_val   (mem_val),
        .stack_top (stack_top),
        .dec       (dec)
    );

    nfu_rstack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk  (clk),
        .rst  (rst),
        .push (step_valid & dec.push),
        .pop  (step_valid & dec.pop),
        .din  (dec.push_val),
        .top  (stack_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            fx_q    <= '0;
        end else begin
            we_q <= 1'b0;
            fx_q <= '0;
            if (step_valid) begin
                pc_q    <= dec.pc;
                we_q    <= dec.reg_we;
                wdata_q <= dec.wr_val;
                fx_q    <= dec.fx;
            end
        end
    end

    assign pc        = pc_q;
    assign reg_we    = we_q;
    assign reg_wdata = wdata_q;
    assign set_carry = fx_q.set_c;
    assign clr_carry = fx_q.clr_c;
    assign set_xm    = fx_q.set_xm;
    assign int_on    = fx_q.int_on;
endmodule

// File: rtl/nfu_chk.sv
module nfu_chk
    import nfu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             step_valid,
    input logic [3:0]       step_op,
    input logic [LEN_W-1:0] step_len,
    input logic [PC_W-1:0]  imm,
    input logic             cond,
    input logic [PC_W-1:0]  pc,
    input logic             reg_we,
    input logic             set_carry,
    input logic             clr_carry,
    input logic             set_xm,
    input logic             int_on
);
    logic [3:0] fx;
    assign fx = {set_carry, clr_carry, set_xm, int_on};

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc == '0 && !reg_we && fx == 4'b0)); // R1

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_op == 4'd0) |=> pc == $past(pc) + PC_W'($past(step_len))); // R2

    AST_BRANCH_FALL: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_op == 4'd1 && !cond) |=> pc == $past(pc) + PC_W'($past(step_len))); // R3

    AST_ABS_JUMP: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_op == 4'd4) |=> pc == $past(imm)); // R7

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fx)); // R8

    AST_PULSE_ONLY_RET: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_op != 4'd6) |=> fx == 4'b0); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> ($stable(pc) && !reg_we && fx == 4'b0)); // R14
endmodule

bind nib_flow_unit nfu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_valid (step_valid),
    .step_op    (step_op),
    .step_len   (step_len),
    .imm        (imm),
    .cond       (cond),
    .pc         (pc),
    .reg_we     (reg_we),
    .set_carry  (set_carry),
    .clr_carry  (clr_carry),
    .set_xm     (set_xm),
    .int_on     (int_on)
);

// File: tb/nib_flow_unit_bench.sv
module nib_flow_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_valid = 1'b0;
    logic [3:0]  step_op = '0;
    logic [4:0]  step_len = '0;
    logic [2:0]  step_pos = '0;
    logic [2:0]  step_nibs = '0;
    logic [19:0] imm = '0;
    logic        cond = 1'b0;
    logic [2:0]  step_ret = '0;
    logic [19:0] reg_val = '0;
    logic [19:0] mem_val = '0;
    logic [19:0] pc;
    logic        reg_we;
    logic [19:0] reg_wdata;
    logic        set_carry, clr_carry, set_xm, int_on;

    nib_flow_unit u_nib_flow_unit (.*);

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // scoreboard queues
    logic [19:0] q_pc [$];
    logic        q_we [$];
    logic [19:0] q_wd [$];
    logic [3:0]  q_fx [$];
    string       q_tag [$];

    // reference model state
    logic [19:0] m_pc = '0;
    logic [19:0] m_stk [8];

    function automatic logic [19:0] sx(logic [19:0] v, int n);
        case (n)
            2: return {{12{v[7]}}, v[7:0]};
            3: return {{8{v[11]}}, v[11:0]};
            4: return {{4{v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic void m_push(logic [19:0] v);
        for (int i = 7; i > 0; i--) m_stk[i] = m_stk[i-1];
        m_stk[0] = v;
    endfunction

    function automatic logic [19:0] m_pop();
        logic [19:0] t;
        t = m_stk[0];
        for (int i = 0; i < 7; i++) m_stk[i] = m_stk[i+1];
        m_stk[7] = '0;
        return t;
    endfunction

    task automatic step(input logic [3:0] op, input logic [4:0] len,
                        input logic [2:0] pos, input logic [2:0] nb,
                        input logic [19:0] im, input logic cd,
                        input logic [2:0] rk, input logic [19:0] rv,
                        input logic [19:0] mv, input string tag);
        logic [19:0] nx, base, e_pc, e_wd;
        logic        e_we;
        logic [3:0]  e_fx;
        nx   = m_pc + 20'(len);
        base = m_pc + 20'(pos);
        e_pc = nx; e_we = 1'b0; e_wd = '0; e_fx = '0;
        case (op)
            4'd1: if (cd) begin
                      if (im[7:0] == 8'h00) e_pc = m_pop();
                      else e_pc = base + sx(im, 2);
                  end
            4'd2: e_pc = base + sx(im, int'(nb));
            4'd3: begin m_push(nx); e_pc = nx + sx(im, int'(nb)); end
            4'd4: e_pc = im;
            4'd5: begin m_push(nx); e_pc = im; end
            4'd6: begin
                      e_pc = m_pop();
                      case (rk)
                          3'd1: e_fx = 4'b1000;
                          3'd2: e_fx = 4'b0100;
                          3'd3: e_fx = 4'b0010;
                          3'd4: e_fx = 4'b0001;
                          default: e_fx = 4'b0000;
                      endcase
                  end
            4'd7: e_pc = rv;
            4'd8: begin e_we = 1'b1; e_wd = nx; end
            4'd9: begin e_pc = rv; e_we = 1'b1; e_wd = nx; end
            4'd10: e_pc = mv;
            4'd11: m_push(rv);
            4'd12: begin e_we = 1'b1; e_wd = m_pop(); end
            default: e_pc = nx;
        endcase
        m_pc = e_pc;
        step_valid = 1'b1; step_op = op; step_len = len; step_pos = pos;
        step_nibs = nb; imm = im; cond = cd; step_ret = rk;
        reg_val = rv; mem_val = mv;
        q_pc.push_back(e_pc); q_we.push_back(e_we); q_wd.push_back(e_wd);
        q_fx.push_back(e_fx); q_tag.push_back(tag);
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    // monitor
    logic due = 1'b0;
    always @(posedge clk) due <= step_valid;

    always @(negedge clk) begin
        if (due && q_pc.size() > 0) begin
            logic [19:0] e_pc, e_wd;
            logic        e_we;
            logic [3:0]  e_fx;
            string       tg;
            e_pc = q_pc.pop_front(); e_we = q_we.pop_front();
            e_wd = q_wd.pop_front(); e_fx = q_fx.pop_front();
            tg   = q_tag.pop_front();
            n_chk++;
            if (pc !== e_pc || reg_we !== e_we || (e_we && reg_wdata !== e_wd) ||
                {set_carry, clr_carry, set_xm, int_on} !== e_fx) begin
                n_fail++;
                $display("FAIL %s: pc=%h we=%b wd=%h fx=%b expected pc=%h we=%b wd=%h fx=%b",
                         tg, pc, reg_we, reg_wdata, {set_carry, clr_carry, set_xm, int_on},
                         e_pc, e_we, e_wd, e_fx);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_chk++;
        if (pc !== 20'h0 || reg_we !== 1'b0 || {set_carry, clr_carry, set_xm, int_on} !== 4'b0) begin
            n_fail++;
            $display("FAIL R1: pc=%h we=%b expected pc=00000 we=0", pc, reg_we);
        end
        step(4'd0,  5'd3, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0, 20'h0, "R2 sequential");
        step(4'd15, 5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0, 20'h0, "R2 unused code");
        step(4'd4,  5'd7, 3'd0, 3'd0, 20'h12340, 1'b0, 3'd0, 20'h0, 20'h0, "R7 absolute jump");
        step(4'd1,  5'd5, 3'd3, 3'd0, 20'h00005, 1'b0, 3'd0, 20'h0, 20'h0, "R3 branch not taken");
        step(4'd1,  5'd3, 3'd1, 3'd0, 20'h000F6, 1'b1, 3'd0, 20'h0, 20'h0, "R3 branch taken back");
        step(4'd2,  5'd4, 3'd1, 3'd3, 20'h00F00, 1'b0, 3'd0, 20'h0, 20'h0, "R5 jump 3 nibbles");
        step(4'd2,  5'd6, 3'd2, 3'd4, 20'h01001, 1'b0, 3'd0, 20'h0, 20'h0, "R5 jump 4 nibbles");
        step(4'd3,  5'd4, 3'd1, 3'd3, 20'h00040, 1'b0, 3'd0, 20'h0, 20'h0, "R6 relative call");
        step(4'd6,  5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd1, 20'h0, 20'h0, "R8 return set carry");
        step(4'd3,  5'd6, 3'd2, 3'd4, 20'h0FFF0, 1'b0, 3'd0, 20'h0, 20'h0, "R6 call back 4 nibbles");
        step(4'd1,  5'd5, 3'd3, 3'd0, 20'h00000, 1'b0, 3'd0, 20'h0, 20'h0, "R4 zero offset not taken");
        step(4'd1,  5'd5, 3'd3, 3'd0, 20'h00000, 1'b1, 3'd0, 20'h0, 20'h0, "R4 conditional return");
        step(4'd5,  5'd7, 3'd0, 3'd0, 20'h30000, 1'b0, 3'd0, 20'h0, 20'h0, "R7 absolute call");
        step(4'd6,  5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd2, 20'h0, 20'h0, "R8 return clear carry");
        step(4'd5,  5'd7, 3'd0, 3'd0, 20'h31000, 1'b0, 3'd0, 20'h0, 20'h0, "R7 absolute call");
        step(4'd6,  5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd3, 20'h0, 20'h0, "R8 return set xm");
        step(4'd5,  5'd7, 3'd0, 3'd0, 20'h32000, 1'b0, 3'd0, 20'h0, 20'h0, "R7 absolute call");
        step(4'd6,  5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd4, 20'h0, 20'h0, "R8 return int on");
        // R12: nine nested calls overflow the 8-entry stack
        for (int k = 1; k <= 9; k++)
            step(4'd5, 5'd7, 3'd0, 3'd0, 20'(k * 20'h01100), 1'b0, 3'd0, 20'h0, 20'h0, "R12 overflow call");
        for (int k = 1; k <= 9; k++)
            step(4'd6, 5'd2, 3'd0, 3'd0, 20'h0, 1'b0, 3'd0, 20'h0, 20'h0, "R12 unwind return");
        step(4'd7,  5'd4, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'hABCDE, 20'h0, "R9 register to pc");
        step(4'd8,  5'd4, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0,     20'h0, "R9 pc to register");
        step(4'd9,  5'd4, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h11111, 20'h0, "R9 swap pc");
        step(4'd10, 5'd4, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0, 20'h54321, "R10 indirect jump");
        step(4'd11, 5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0BEEF, 20'h0, "R11 push register");
        step(4'd12, 5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0,     20'h0, "R11 pop register");
        step(4'd12, 5'd2, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0,     20'h0, "R12 pop empty");
        step(4'd4,  5'd7, 3'd0, 3'd0, 20'hFFFFE, 1'b0, 3'd0, 20'h0, 20'h0, "R13 jump near top");
        step(4'd0,  5'd4, 3'd0, 3'd0, 20'h0,     1'b0, 3'd0, 20'h0, 20'h0, "R13 wrap forward");
        step(4'd1,  5'd3, 3'd1, 3'd0, 20'h000F6, 1'b1, 3'd0, 20'h0, 20'h0, "R13 wrap backward");
        // R14: idle cycles leave pc and stack alone
        repeat (3) @(negedge clk);
        n_chk++;
        if (pc !== m_pc || reg_we !== 1'b0) begin
            n_fail++;
            $display("FAIL R14: pc=%h we=%b expected pc=%h we=0", pc, reg_we, m_pc);
        end
        step(4'd12, 5'd2, 3'd0, 3'd0, 20'h0, 1'b0, 3'd0, 20'h0, 20'h0, "R14 stack untouched by idle");
        @(negedge clk);
        finish_run();
    end
endmodule